// File: doc/BRIEF.md
# SD SPI-Mode Command Issuer

This block sends one memory-card command over an SPI link that is driven one byte at a time, then gathers the card's reply. A request carries a 6-bit command index, a 32-bit argument, a response length of one or five bytes, a flag that turns on the response search, and the byte the search looks for. The block works through a byte-exchange port. It offers a transmit byte together with a request, waits for the port to report completion, and then takes the received byte. The bit shifter, chip-select handling and card start-up sequencing are not part of this block. Other logic supplies them.

Each command goes out as a seven-byte frame that ends in a CRC7 byte. One byte of turnaround follows and is discarded. The reply is then collected in one of two ways. If the search is off, the bytes that follow are taken directly. If the search is on, the block watches a small number of bytes for the expected value, and when it finds it, that byte becomes response byte 0 and the rest follow in order. If the search finds nothing, the command ends with a timeout flag. A one-cycle done pulse marks the end of every command.

Top module: `sdspi_cmd_issuer`

## Requirements
- R1: The first seven exchanges of a command transmit, in order: 0xFF; then 0x40 OR the command index; then the four argument bytes, most significant first; then the CRC byte.
- R2: The CRC byte equals the CRC7 of the command byte and the four argument bytes, shifted left by one with bit 0 set. The CRC7 uses polynomial x^7+x^3+1, starts at zero and takes bits MSB first. The index 0 with argument 0 gives 0x95, and index 8 with argument 0x1AA gives 0x87.
- R3: Exactly one byte is exchanged and discarded between the frame and the start of response collection.
- R4: With the search on, the block tries at most 8 bytes. If none equals the expected value, done and timeout are asserted together after exactly 16 exchanges in total, and both response outputs read zero.
- R5: With the search on, the first matching byte is reported as response byte 0 (rsp_first). For a 5-byte response, the next four bytes fill rsp_word.
- R6: With the search off, the response bytes are the ones that directly follow the discarded byte, with no search. The command takes 8 + length exchanges.
- R7: For a 5-byte response, rsp_word is {byte1, byte2, byte3, byte4}, with byte 1 in bits 31:24. For a 1-byte response, rsp_word reads zero.
- R8: At most one exchange is outstanding. A request is never asserted in two consecutive cycles, the next request waits for xfer_done, and every exchange after the frame transmits 0xFF.
- R9: A cmd_start while busy is high is ignored. The current command completes with its own frame and exchange count.
- R10: done is high for exactly one cycle, and busy is high in that cycle. busy is low in the following cycle. After reset, busy, done, timeout, xfer_req and both response outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_start | input | 1 | Starts a command when the block is idle |
| cmd_index | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| rsp_long | input | 1 | 1: five-byte response, 0: one byte |
| match_en | input | 1 | Enables the response search |
| match_val | input | 8 | Byte the search looks for |
| xfer_req | output | 1 | Request for one byte exchange |
| xfer_tx | output | 8 | Byte to transmit, valid with xfer_req |
| xfer_done | input | 1 | Exchange finished, xfer_rx valid |
| xfer_rx | input | 8 | Byte received by the exchange |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle end-of-command pulse |
| timeout | output | 1 | Search failed; valid with done |
| rsp_first | output | 8 | Response byte 0 |
| rsp_word | output | 32 | Response bytes 1 to 4 |

## Verification
A wrong frame index or a corrupt CRC shows up within the first seven exchanges as a wrong transmit byte. A miscounted search or collection state shows up at done in three ways: the total exchange count is off, the timeout flag is wrong, or the response bytes are shifted by one position. The bench therefore logs every transmitted byte and counts exchanges per command, and it compares these against a model of the reply stream. Random port latencies and randomly placed matches bring out slips in the handshake or in the try counter within one command.

// File: rtl/sdspi_pkg.sv
// Shared definitions for the SD SPI-mode command issuer.
package sdspi_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEND,
        ST_SKIP,
        ST_HUNT,
        ST_TAKE,
        ST_FIN
    } issue_state_t;

    localparam logic [7:0] FILL_BYTE   = 8'hFF;
    localparam int         FRAME_BYTES = 7;
endpackage

// File: rtl/sdspi_crc7.sv
// CRC7 generator, fully combinational.
// Polynomial x^7+x^3+1, initial value zero, bits consumed MSB first.
// Assumes DATA_W is small enough to unroll (40 bits here).
module sdspi_crc7 #(
    parameter int DATA_W = 40
) (
    input  logic [DATA_W-1:0] data,
    output logic [6:0]        crc
);
    // Bit-serial division, unrolled over the whole input.
    always_comb begin
        logic [6:0] acc;
        logic       fb;
        acc = '0;
        for (int i = DATA_W - 1; i >= 0; i--) begin
            fb  = acc[6] ^ data[i];
            acc = {acc[5:0], 1'b0};
            if (fb) acc = acc ^ 7'h09;
        end
        crc = acc;
    end
endmodule

// File: rtl/sdspi_frame_builder.sv
// Selects one byte of the command frame.
// Order: filler, command byte, argument bytes (MSB first), CRC byte.
// Assumes IDX_W is 6, so 0x40 | index fits a byte.
module sdspi_frame_builder #(
    parameter int IDX_W = 6,
    parameter int ARG_W = 32,
    parameter int SEL_W = 3
) (
    input  logic [IDX_W-1:0] cmd_index,
    input  logic [ARG_W-1:0] cmd_arg,
    input  logic [SEL_W-1:0] sel,
    output logic [7:0]       frame_byte
);
    localparam int ARG_BYTES = ARG_W / 8;
    localparam int HDR_BYTES = ARG_BYTES + 1;
    localparam int HDR_W     = 8 * HDR_BYTES;

    logic [7:0]       cmd_byte;
    logic [HDR_W-1:0] header;
    logic [6:0]       crc;
    logic [7:0]       hdr_b [HDR_BYTES];

    assign cmd_byte = 8'h40 | 8'(cmd_index);
    assign header   = {cmd_byte, cmd_arg};

    sdspi_crc7 #(.DATA_W(HDR_W)) u_crc (
        .data (header),
        .crc  (crc)
    );

    // Split the header into bytes, most significant first.
    for (genvar g = 0; g < HDR_BYTES; g++) begin : g_hdr
        assign hdr_b[g] = header[HDR_W - 1 - 8*g -: 8];
    end

    // Pick the byte for the current frame position.
    always_comb begin
        if (sel == '0)
            frame_byte = sdspi_pkg::FILL_BYTE;
        else if (int'(sel) <= HDR_BYTES)
            frame_byte = hdr_b[int'(sel) - 1];
        else
            frame_byte = {crc, 1'b1};
    end
endmodule

// File: rtl/sdspi_rsp_capture.sv
// Response byte store with an indexed write port.
// Assumes clear and wr_en are not asserted in the same cycle.
module sdspi_rsp_capture #(
    parameter int NBYTES = 5,
    parameter int IDX_W  = $clog2(NBYTES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic [7:0]          wr_data,
    output logic [8*NBYTES-1:0] bytes_flat
);
    for (genvar g = 0; g < NBYTES; g++) begin : g_byte
        logic [7:0] q;
        // Hold one response byte; cleared at reset and on each new command.
        always_ff @(posedge clk) begin
            if (!rst_n || clear)
                q <= '0;
            else if (wr_en && wr_idx == IDX_W'(g))
                q <= wr_data;
        end
        assign bytes_flat[8*g +: 8] = q;
    end
endmodule

// File: rtl/sdspi_cmd_issuer.sv
// SD SPI-mode command issuer: sends a 7-byte frame, discards one byte,
// optionally searches for an expected byte, then collects the response.
// Assumes the byte port answers each request with xfer_done at least one
// cycle after the request and never without a request.
module sdspi_cmd_issuer #(
    parameter int TRY_LIMIT = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_start,
    input  logic [5:0]  cmd_index,
    input  logic [31:0] cmd_arg,
    input  logic        rsp_long,
    input  logic        match_en,
    input  logic [7:0]  match_val,
    output logic        xfer_req,
    output logic [7:0]  xfer_tx,
    input  logic        xfer_done,
    input  logic [7:0]  xfer_rx,
    output logic        busy,
    output logic        done,
    output logic        timeout,
    output logic [7:0]  rsp_first,
    output logic [31:0] rsp_word
);
    import sdspi_pkg::*;

    localparam int RSP_MAX = 5;
    localparam int RIDX_W  = $clog2(RSP_MAX);
    localparam int SEL_W   = $clog2(FRAME_BYTES);
    localparam int TRY_W   = $clog2(TRY_LIMIT + 1);
    localparam logic [SEL_W-1:0]  SEL_LAST = SEL_W'(FRAME_BYTES - 1);
    localparam logic [TRY_W-1:0]  TRY_LAST = TRY_W'(TRY_LIMIT - 1);

    issue_state_t      state;
    logic              waiting;
    logic [SEL_W-1:0]  sel;
    logic [TRY_W-1:0]  tries;
    logic [RIDX_W-1:0] ridx;
    logic [RIDX_W-1:0] ridx_last;
    logic [5:0]        idx_q;
    logic [31:0]       arg_q;
    logic              long_q;
    logic              match_q;
    logic [7:0]        val_q;
    logic              to_q;
    logic              accept;
    logic              got;
    logic              hit;
    logic [7:0]        frame_byte;
    logic              cap_wr;
    logic [RIDX_W-1:0] cap_idx;
    logic [8*RSP_MAX-1:0] cap_bytes;

    assign accept    = (state == ST_IDLE) && cmd_start;
    assign got       = waiting && xfer_done;
    assign hit       = (xfer_rx == val_q);
    assign ridx_last = long_q ? RIDX_W'(RSP_MAX - 1) : '0;

    assign busy    = (state != ST_IDLE);
    assign done    = (state == ST_FIN);
    assign timeout = done && to_q;

    assign xfer_req = !waiting && (state == ST_SEND || state == ST_SKIP ||
                                   state == ST_HUNT || state == ST_TAKE);
    assign xfer_tx  = (state == ST_SEND) ? frame_byte : FILL_BYTE;

    sdspi_frame_builder #(.IDX_W(6), .ARG_W(32), .SEL_W(SEL_W)) u_frame (
        .cmd_index  (idx_q),
        .cmd_arg    (arg_q),
        .sel        (sel),
        .frame_byte (frame_byte)
    );

    assign cap_wr  = got && ((state == ST_HUNT && hit) || state == ST_TAKE);
    assign cap_idx = (state == ST_HUNT) ? '0 : ridx;

    sdspi_rsp_capture #(.NBYTES(RSP_MAX), .IDX_W(RIDX_W)) u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (accept),
        .wr_en      (cap_wr),
        .wr_idx     (cap_idx),
        .wr_data    (xfer_rx),
        .bytes_flat (cap_bytes)
    );

    assign rsp_first = cap_bytes[7:0];
    assign rsp_word  = {cap_bytes[15:8], cap_bytes[23:16],
                        cap_bytes[31:24], cap_bytes[39:32]};

    // Track the one outstanding exchange.
    always_ff @(posedge clk) begin
        if (!rst_n)
            waiting <= 1'b0;
        else if (xfer_req)
            waiting <= 1'b1;
        else if (got)
            waiting <= 1'b0;
    end

    // Latch the command when it is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q   <= '0;
            arg_q   <= '0;
            long_q  <= 1'b0;
            match_q <= 1'b0;
            val_q   <= '0;
        end else if (accept) begin
            idx_q   <= cmd_index;
            arg_q   <= cmd_arg;
            long_q  <= rsp_long;
            match_q <= match_en;
            val_q   <= match_val;
        end
    end

    // Command sequencer: frame, turnaround byte, search, collection, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            sel   <= '0;
            tries <= '0;
            ridx  <= '0;
            to_q  <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        sel   <= '0;
                        to_q  <= 1'b0;
                        state <= ST_SEND;
                    end
                end
                ST_SEND: begin
                    if (got) begin
                        if (sel == SEL_LAST) state <= ST_SKIP;
                        else                 sel <= sel + 1'b1;
                    end
                end
                ST_SKIP: begin
                    if (got) begin
                        tries <= '0;
                        ridx  <= '0;
                        state <= match_q ? ST_HUNT : ST_TAKE;
                    end
                end
                ST_HUNT: begin
                    if (got) begin
                        if (hit) begin
                            ridx  <= RIDX_W'(1);
                            state <= long_q ? ST_TAKE : ST_FIN;
                        end else if (tries == TRY_LAST) begin
                            to_q  <= 1'b1;
                            state <= ST_FIN;
                        end else begin
                            tries <= tries + 1'b1;
                        end
                    end
                end
                ST_TAKE: begin
                    if (got) begin
                        if (ridx == ridx_last) state <= ST_FIN;
                        else                   ridx  <= ridx + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sdspi_issuer_chk.sv
// Port-level protocol checks for sdspi_cmd_issuer, attached by bind.
// Counts exchange requests per command to check frame bytes and budgets.
module sdspi_issuer_chk #(
    parameter int TRY_LIMIT = 8
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_start,
    input logic [5:0] cmd_index,
    input logic       rsp_long,
    input logic       match_en,
    input logic       xfer_req,
    input logic [7:0] xfer_tx,
    input logic       busy,
    input logic       done,
    input logic       timeout
);
    logic [7:0] req_cnt;
    logic [5:0] idx_c;
    logic       long_c;
    logic       match_c;

    // Per-command request counter and latched command fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_cnt <= '0;
            idx_c   <= '0;
            long_c  <= 1'b0;
            match_c <= 1'b0;
        end else if (cmd_start && !busy) begin
            req_cnt <= '0;
            idx_c   <= cmd_index;
            long_c  <= rsp_long;
            match_c <= match_en;
        end else if (xfer_req) begin
            req_cnt <= req_cnt + 1'b1;
        end
    end

    p_filler_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && req_cnt == 8'd0) |-> (xfer_tx == 8'hFF));

    p_cmd_byte_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && req_cnt == 8'd1) |-> (xfer_tx == {2'b01, idx_c}));

    p_read_filler_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && req_cnt >= 8'd7) |-> (xfer_tx == 8'hFF));

    p_single_outstanding_r8: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req |=> !xfer_req);

    p_timeout_budget_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && timeout) |-> (match_c && req_cnt == 8'(8 + TRY_LIMIT)));

    p_direct_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !match_c) |-> (req_cnt == (long_c ? 8'd13 : 8'd9)));

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    p_busy_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cmd_start));
endmodule

bind sdspi_cmd_issuer sdspi_issuer_chk #(.TRY_LIMIT(TRY_LIMIT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_start (cmd_start),
    .cmd_index (cmd_index),
    .rsp_long  (rsp_long),
    .match_en  (match_en),
    .xfer_req  (xfer_req),
    .xfer_tx   (xfer_tx),
    .busy      (busy),
    .done      (done),
    .timeout   (timeout)
);

// File: tb/sim_sdspi_cmd_issuer.sv
`timescale 1ns/1ps
// Bench for sdspi_cmd_issuer: byte-port model with random latency,
// directed corner cases and seeded random commands.
module sim_sdspi_cmd_issuer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_start = 1'b0;
    logic [5:0]  cmd_index = '0;
    logic [31:0] cmd_arg = '0;
    logic        rsp_long = 1'b0;
    logic        match_en = 1'b0;
    logic [7:0]  match_val = '0;
    logic        xfer_req;
    logic [7:0]  xfer_tx;
    logic        xfer_done = 1'b0;
    logic [7:0]  xfer_rx = '0;
    logic        busy, done, timeout;
    logic [7:0]  rsp_first;
    logic [31:0] rsp_word;

    int errors = 0;
    int checks = 0;
    int seed_dummy;

    logic [7:0] strm  [0:23];
    logic [7:0] txlog [0:63];
    int n_ex = 0;
    int pend = 0;
    int lat  = 0;

    always #2.5 clk = ~clk;

    sdspi_cmd_issuer u0 (.*);

    // Check helper: counts and reports.
    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Reference CRC7 from the requirement text.
    function automatic logic [6:0] ref_crc(input logic [39:0] d);
        logic [6:0] c = '0;
        for (int i = 39; i >= 0; i--) begin
            logic f = c[6] ^ d[i];
            c = {c[5:0], 1'b0};
            if (f) c ^= 7'h09;
        end
        return c;
    endfunction

    // Byte-port model: answers each request after 0 to 2 idle cycles.
    always @(negedge clk) begin
        xfer_done = 1'b0;
        if (pend != 0) begin
            if (lat == 0) begin
                xfer_done = 1'b1;
                xfer_rx   = (n_ex <= 7) ? 8'hFF : strm[(n_ex - 8) % 24];
                pend      = 0;
            end else begin
                lat--;
            end
        end else if (xfer_req) begin
            txlog[n_ex % 64] = xfer_tx;
            n_ex++;
            pend = 1;
            lat  = $urandom % 3;
        end
    end

    // Run one command and compare against the modeled reply stream.
    task automatic run_cmd(input logic [5:0] idx, input logic [31:0] arg,
                           input bit lng, input bit mt, input logic [7:0] val,
                           input bit poke);
        int k, cyc, exp_cnt, len, from;
        bit exp_to;
        logic [7:0]  exp_first;
        logic [31:0] exp_word;
        logic [55:0] exp_frame, act_frame;
        bit all_ff;
        len = lng ? 5 : 1;
        exp_to = 1'b0; exp_first = '0; exp_word = '0;
        from = 1;
        if (mt) begin
            k = 0;
            for (int i = 1; i <= 8; i++)
                if (k == 0 && strm[i] == val) k = i;
            if (k == 0) begin
                exp_to = 1'b1;
                exp_cnt = 16;
            end else begin
                exp_first = val;
                from = k;
                exp_cnt = 8 + k + len - 1;
            end
        end else begin
            exp_first = strm[1];
            exp_cnt = 8 + len;
        end
        if (lng && !exp_to)
            exp_word = {strm[from+1], strm[from+2], strm[from+3], strm[from+4]};

        @(negedge clk);
        n_ex = 0;
        cmd_index = idx; cmd_arg = arg; rsp_long = lng;
        match_en = mt; match_val = val; cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
        cmd_index = ~idx; cmd_arg = ~arg; match_val = ~val;
        chk(busy == 1'b1, "R10 busy after start", busy, 1);
        cyc = 0;
        while (!done && cyc < 1000) begin
            @(negedge clk);
            cyc++;
            if (poke && cyc == 5) cmd_start = 1'b1;
            else cmd_start = 1'b0;
        end
        cmd_start = 1'b0;
        if (!done) begin
            chk(0, "R10 done never seen", 0, 1);
            return;
        end
        chk(busy == 1'b1, "R10 busy with done", busy, 1);
        chk(timeout == exp_to, "R4 timeout flag", timeout, exp_to);
        chk(rsp_first == exp_first, mt ? "R5 first byte" : "R6 first byte",
            rsp_first, exp_first);
        chk(rsp_word == exp_word, "R7 response word", rsp_word, exp_word);
        chk(n_ex == exp_cnt, exp_to ? "R4 exchange count" :
            (mt ? "R3 exchange count" : "R6 exchange count"), n_ex, exp_cnt);
        exp_frame = {8'hFF, 8'h40 | {2'b00, idx}, arg,
                     ref_crc({8'h40 | {2'b00, idx}, arg}), 1'b1};
        act_frame = {txlog[0], txlog[1], txlog[2], txlog[3],
                     txlog[4], txlog[5], txlog[6]};
        chk(act_frame == exp_frame, poke ? "R9 frame kept" : "R1 frame bytes",
            act_frame, exp_frame);
        all_ff = 1'b1;
        for (int i = 7; i < n_ex && i < 64; i++)
            if (txlog[i] != 8'hFF) all_ff = 1'b0;
        chk(all_ff, "R8 read filler", all_ff, 1);
        @(negedge clk);
        chk(!done && !busy, "R10 done one cycle", {done, busy}, 0);
    endtask

    // Fill the stream; place the match at pos (9 means none in budget).
    task automatic fill(input logic [7:0] val, input int pos);
        for (int i = 0; i < 24; i++) begin
            logic [7:0] b = 8'($urandom);
            if (b == val) b = val ^ 8'h5A;
            strm[i] = b;
        end
        if (pos >= 1 && pos <= 8) strm[pos] = val;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "R10 watchdog", 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        seed_dummy = $urandom(32'h5D1C);
        repeat (3) @(negedge clk);
        chk({busy, done, timeout, xfer_req} == 4'b0 && rsp_first == 0 && rsp_word == 0,
            "R10 reset state", {busy, done, timeout, xfer_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 known CRC bytes.
        fill(8'h01, 1);
        run_cmd(6'd0, 32'h0, 1'b0, 1'b1, 8'h01, 1'b0);
        chk(txlog[6] == 8'h95, "R2 crc index0", txlog[6], 8'h95);
        fill(8'h01, 1);
        run_cmd(6'd8, 32'h1AA, 1'b1, 1'b1, 8'h01, 1'b0);
        chk(txlog[6] == 8'h87, "R2 crc index8", txlog[6], 8'h87);
        // R4/R5 match on the last try, then no match.
        fill(8'h00, 8);
        run_cmd(6'd16, 32'h200, 1'b1, 1'b1, 8'h00, 1'b0);
        fill(8'h00, 9);
        run_cmd(6'd13, 32'h0, 1'b0, 1'b1, 8'h00, 1'b0);
        // R6 direct read, both lengths.
        fill(8'h00, 9);
        run_cmd(6'd58, 32'hDEADBEEF, 1'b1, 1'b0, 8'h00, 1'b0);
        fill(8'h00, 9);
        run_cmd(6'd41, 32'h40000000, 1'b0, 1'b0, 8'h00, 1'b0);
        // R9 start while busy.
        fill(8'h01, 3);
        run_cmd(6'd55, 32'h12345678, 1'b1, 1'b1, 8'h01, 1'b1);

        for (int t = 0; t < 60; t++) begin
            logic [7:0] v = 8'($urandom);
            fill(v, 1 + ($urandom % 9));
            run_cmd(6'($urandom), $urandom, 1'($urandom), 1'($urandom), v,
                    ($urandom % 5) == 0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule